// File: doc/BRIEF.md
# Programmable Display Sync Counter Bank

A bank of generic timing counters that together build the horizontal, vertical and active-window waveforms of a display. No counter is wired as "horizontal" or "vertical". Each one advances on a selectable tick source: the pixel clock, which is the block clock, or the wrap pulse of another counter in the bank. Line, frame and data-enable timing is built by chaining counters. For example, a line counter runs on the pixel clock. A frame counter runs on the line counter's pulse. An active-row counter is offset by sync plus back-porch lines and cleared once per frame. An active-pixel counter is restarted by the active-row counter and repeats once per visible pixel.

Each counter has the following settings:
- a period, programmed as ticks minus one;
- a start offset, counted in ticks of its own offset source;
- a repeat limit, where zero means free-running;
- a restart (clear) source;
- two edge positions, in half-tick units, that shape its level output;
- a polarity bit.

Software programs the counters through a single-cycle write port. Any value that does not fit its field is refused, and the refusal is flagged. A global enable holds every counter stopped while it is low. When it rises, all counters start on the same clock edge.

Top module: `dsc_bank`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into counter `wr_idx` at field `wr_addr`. Field 0 is the run count (12 bits) and field 1 the offset (12 bits). Field 2 is the repeat count (12 bits). Field 3 is the set edge and field 4 the reset edge (10 bits each). Field 5 holds the selectors: bits [3:0] the run source, [7:4] the offset source, [11:8] the clear source and bit 12 the level polarity. Bits 15:13 of field 5 are ignored.
- R2: A running counter advances one position per tick of its run source. After position equal to the run count it returns to 0. In the cycle after that wrap edge, `tick_o` of that counter is high for one cycle, so the period is run count plus one ticks.
- R3: Selector encoding: 0 means no source (never ticks) and 1 means every clock cycle. A value k+2 means the `tick_o` pulse of counter k as seen on the previous cycle.
- R4: A (re)start sets position 0. With a zero offset the counter runs at once. Otherwise it waits for that many ticks of its offset source and runs on the edge of the last one.
- R5: A repeat count of 0 makes the counter wrap forever. A repeat count N stops it after its N-th wrap; it produces no further pulses until restarted.
- R6: A tick of the clear source restarts the counter, as in R4. The restart takes priority over a wrap on the same edge.
- R7: `lvl_o` is the polarity bit XOR an active flag, registered. The flag is set while the counter is running and twice its position lies in [set edge, reset edge). The output therefore reflects the state one cycle earlier.
- R8: A write is refused in each of these cases: the run, offset or repeat value is 0x1000 or more; an edge value is 0x400 or more; a selector exceeds the bank size plus one; the field address is 6 or 7; or `wr_idx` is not below the bank size. A refused write changes no setting. `wr_err` is high in the cycle after a refused write and low after any other cycle.
- R9: While `en` is low every counter is stopped, `tick_o` is 0 and `lvl_o` equals the polarity bits. The first edge with `en` high restarts all counters together, as in R4.
- R10: Synchronous active-high reset clears all settings and stops all counters. After reset, `tick_o`, `lvl_o` and `wr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global run enable |
| wr_en | input | 1 | Setting write strobe |
| wr_idx | input | 3 | Counter index of the write |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 16 | Write value |
| wr_err | output | 1 | Previous write was refused |
| tick_o | output | 6 | Per-counter wrap pulse |
| lvl_o | output | 6 | Per-counter level waveform |

## Verification
Every result of this block is due one edge after the state that causes it. A wrap on edge n shows on `tick_o` after edge n, and a downstream counter acts on it at edge n+1. The level shows the position held before edge n. `wr_err` answers the write captured on edge n. The bench drives inputs and samples outputs on the falling edge. Between rising edges it steps a behavioural model whose outputs follow the same one-edge rule, and compares all three outputs on every cycle. Directed windows count pulses from a known start edge against hand-derived totals: nine wraps of a period-10 counter in 100 cycles, and exactly two wraps from a limit-2 counter.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int CNT_W  = 12;
  localparam int EDGE_W = 10;
  localparam int SEL_W  = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] FLD_RUN = 3'd0;
  localparam logic [ADDR_W-1:0] FLD_OFS = 3'd1;
  localparam logic [ADDR_W-1:0] FLD_REP = 3'd2;
  localparam logic [ADDR_W-1:0] FLD_UP  = 3'd3;
  localparam logic [ADDR_W-1:0] FLD_DN  = 3'd4;
  localparam logic [ADDR_W-1:0] FLD_SEL = 3'd5;

  typedef enum logic [1:0] {ST_STOP, ST_WAIT, ST_RUN, ST_DONE} cnt_state_e;

  typedef struct packed {
    logic [CNT_W-1:0]  run;
    logic [CNT_W-1:0]  ofs;
    logic [CNT_W-1:0]  rep;
    logic [EDGE_W-1:0] up;
    logic [EDGE_W-1:0] dn;
    logic [SEL_W-1:0]  s_run;
    logic [SEL_W-1:0]  s_ofs;
    logic [SEL_W-1:0]  s_clr;
    logic              pol;
  } cnt_cfg_t;
endpackage

// File: rtl/dsc_cfg_regs.sv
module dsc_cfg_regs
  import dsc_pkg::*;
#(
  parameter int NCNT = 6,
  localparam int IDXW = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cnt_cfg_t          cfg [NCNT],
  output logic              wr_err
);
  localparam int SEL_MAX = NCNT + 1;

  logic     bad;
  logic     sel_bad;
  cnt_cfg_t cfg_q [NCNT];
  logic     err_q;

  // each selector nibble must name an existing source
  always_comb begin
    sel_bad = 1'b0;
    for (int s = 0; s < 3; s++) begin
      if (32'(wr_data[s*SEL_W +: SEL_W]) > SEL_MAX) sel_bad = 1'b1;
    end
  end

  always_comb begin
    bad = (32'(wr_idx) >= NCNT);
    case (wr_addr)
      FLD_RUN, FLD_OFS, FLD_REP: if (wr_data[DATA_W-1:CNT_W] != '0) bad = 1'b1;
      FLD_UP, FLD_DN:            if (wr_data[DATA_W-1:EDGE_W] != '0) bad = 1'b1;
      FLD_SEL:                   if (sel_bad) bad = 1'b1;
      default:                   bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCNT; i++) cfg_q[i] <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en && bad;
      if (wr_en && !bad) begin
        for (int i = 0; i < NCNT; i++) begin
          if (32'(wr_idx) == i) begin
            case (wr_addr)
              FLD_RUN: cfg_q[i].run <= wr_data[CNT_W-1:0];
              FLD_OFS: cfg_q[i].ofs <= wr_data[CNT_W-1:0];
              FLD_REP: cfg_q[i].rep <= wr_data[CNT_W-1:0];
              FLD_UP:  cfg_q[i].up  <= wr_data[EDGE_W-1:0];
              FLD_DN:  cfg_q[i].dn  <= wr_data[EDGE_W-1:0];
              default: begin
                cfg_q[i].s_run <= wr_data[SEL_W-1:0];
                cfg_q[i].s_ofs <= wr_data[2*SEL_W-1:SEL_W];
                cfg_q[i].s_clr <= wr_data[3*SEL_W-1:2*SEL_W];
                cfg_q[i].pol   <= wr_data[3*SEL_W];
              end
            endcase
          end
        end
      end
    end
  end

  assign cfg    = cfg_q;
  assign wr_err = err_q;
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter
  import dsc_pkg::*;
#(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  cnt_cfg_t        cfg,
  input  logic [NSRC-1:0] srcs,
  output logic            tick_o,
  output logic            lvl_o
);
  cnt_state_e       st;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] ocnt;
  logic [CNT_W-1:0] reps;
  logic             tick_q;
  logic             lvl_q;
  logic             run_hit, ofs_hit, clr_hit;
  logic             in_win;
  logic [CNT_W:0]   pos2;

  // selector code k+1 picks source k; code 0 picks nothing
  always_comb begin
    run_hit = 1'b0;
    ofs_hit = 1'b0;
    clr_hit = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (32'(cfg.s_run) == k + 1) run_hit = srcs[k];
      if (32'(cfg.s_ofs) == k + 1) ofs_hit = srcs[k];
      if (32'(cfg.s_clr) == k + 1) clr_hit = srcs[k];
    end
  end

  assign pos2   = {pos, 1'b0};
  assign in_win = (st == ST_RUN) &&
                  (pos2 >= (CNT_W+1)'(cfg.up)) &&
                  (pos2 <  (CNT_W+1)'(cfg.dn));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_STOP;
      pos    <= '0;
      ocnt   <= '0;
      reps   <= '0;
      tick_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      lvl_q  <= cfg.pol ^ in_win;
      tick_q <= 1'b0;
      if (!en) begin
        st   <= ST_STOP;
        pos  <= '0;
        ocnt <= '0;
        reps <= '0;
      end else if (st == ST_STOP || clr_hit) begin
        pos  <= '0;
        ocnt <= '0;
        reps <= '0;
        st   <= (cfg.ofs == '0) ? ST_RUN : ST_WAIT;
      end else begin
        case (st)
          ST_WAIT: begin
            if (ofs_hit) begin
              if (ocnt == cfg.ofs - 1'b1) st <= ST_RUN;
              else ocnt <= ocnt + 1'b1;
            end
          end
          ST_RUN: begin
            if (run_hit) begin
              if (pos == cfg.run) begin
                pos    <= '0;
                tick_q <= 1'b1;
                if (cfg.rep != '0) begin
                  if (reps == cfg.rep - 1'b1) st <= ST_DONE;
                  else reps <= reps + 1'b1;
                end
              end else begin
                pos <= pos + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tick_o = tick_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/dsc_bank.sv
module dsc_bank
  import dsc_pkg::*;
#(
  parameter int NCNT = 6,
  localparam int IDXW = (NCNT > 1) ? $clog2(NCNT) : 1,
  localparam int NSRC = NCNT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  output logic [NCNT-1:0]   tick_o,
  output logic [NCNT-1:0]   lvl_o
);
  cnt_cfg_t        cfg [NCNT];
  logic [NSRC-1:0] srcs;
  logic [NCNT-1:0] pol_vec;

  dsc_cfg_regs #(.NCNT(NCNT)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .wr_err  (wr_err)
  );

  // source 0 is the pixel clock itself, source k+1 is counter k's pulse
  assign srcs = {tick_o, 1'b1};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    dsc_counter #(.NSRC(NSRC)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .cfg    (cfg[i]),
      .srcs   (srcs),
      .tick_o (tick_o[i]),
      .lvl_o  (lvl_o[i])
    );
    assign pol_vec[i] = cfg[i].pol;
  end
endmodule

// File: rtl/dsc_bank_chk.sv
module dsc_bank_chk #(
  parameter int NCNT = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic [15:0]     wr_data,
  input logic            wr_err,
  input logic [NCNT-1:0] tick_o,
  input logic [NCNT-1:0] lvl_o,
  input logic [NCNT-1:0] pol_vec
);
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tick_o == '0)); // R9

  AST_STOP_LEVEL_POL: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |=> (lvl_o == $past(pol_vec))); // R9

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (tick_o != '0) |-> $past(en)); // R9

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_err); // R8

  AST_BAD_COUNT_REJECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr <= 3'd2 && wr_data[15:12] != 4'd0) |=> wr_err); // R8

  AST_BAD_EDGE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == 3'd3 || wr_addr == 3'd4) && wr_data[15:10] != 6'd0) |=> wr_err); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (tick_o == '0 && lvl_o == '0 && !wr_err)); // R10
endmodule

bind dsc_bank dsc_bank_chk #(.NCNT(NCNT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .wr_err  (wr_err),
  .tick_o  (tick_o),
  .lvl_o   (lvl_o),
  .pol_vec (pol_vec)
);

// File: tb/tb_dsc_bank.sv
`timescale 1ns/1ps
module tb_dsc_bank;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [2:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          wr_err;
  logic [NC-1:0] tick_o;
  logic [NC-1:0] lvl_o;

  int checks = 0;
  int fails = 0;
  bit live = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dsc_bank #(.NCNT(NC)) dut (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .tick_o(tick_o), .lvl_o(lvl_o)
  );

  // behavioural model: states 0 stopped, 1 waiting, 2 running, 3 finished
  int c_run[NC], c_ofs[NC], c_rep[NC], c_up[NC], c_dn[NC];
  int c_sr[NC], c_so[NC], c_sc[NC];
  bit c_pol[NC];
  int m_st[NC], m_pos[NC], m_oc[NC], m_rp[NC];
  bit m_tk[NC], m_lv[NC], otk[NC];
  bit m_err;

  function automatic bit srcv(int enc);
    if (enc == 0) return 1'b0;
    if (enc == 1) return 1'b1;
    if (enc - 2 < NC) return otk[enc-2];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < NC; i++) otk[i] = m_tk[i];
    live = 1;
    if (rst) begin
      for (int i = 0; i < NC; i++) begin
        c_run[i] = 0; c_ofs[i] = 0; c_rep[i] = 0; c_up[i] = 0; c_dn[i] = 0;
        c_sr[i] = 0; c_so[i] = 0; c_sc[i] = 0; c_pol[i] = 0;
        m_st[i] = 0; m_pos[i] = 0; m_oc[i] = 0; m_rp[i] = 0;
        m_tk[i] = 0; m_lv[i] = 0;
      end
      m_err = 0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        m_lv[i] = c_pol[i] ^ (m_st[i] == 2 && 2*m_pos[i] >= c_up[i] && 2*m_pos[i] < c_dn[i]);
        m_tk[i] = 0;
        if (!en) begin
          m_st[i] = 0; m_pos[i] = 0; m_oc[i] = 0; m_rp[i] = 0;
        end else if (m_st[i] == 0 || srcv(c_sc[i])) begin
          m_pos[i] = 0; m_oc[i] = 0; m_rp[i] = 0;
          m_st[i] = (c_ofs[i] == 0) ? 2 : 1;
        end else if (m_st[i] == 1) begin
          if (srcv(c_so[i])) begin
            if (m_oc[i] == c_ofs[i] - 1) m_st[i] = 2;
            else m_oc[i]++;
          end
        end else if (m_st[i] == 2) begin
          if (srcv(c_sr[i])) begin
            if (m_pos[i] == c_run[i]) begin
              m_pos[i] = 0;
              m_tk[i] = 1;
              if (c_rep[i] != 0) begin
                if (m_rp[i] == c_rep[i] - 1) m_st[i] = 3;
                else m_rp[i]++;
              end
            end else begin
              m_pos[i] = (m_pos[i] + 1) % 4096;
            end
          end
        end
      end
      m_err = 0;
      if (wr_en) begin
        bit bad;
        int d;
        d = int'(wr_data);
        bad = (int'(wr_idx) >= NC);
        case (int'(wr_addr))
          0, 1, 2: if (d >= 'h1000) bad = 1;
          3, 4:    if (d >= 'h400) bad = 1;
          5:       if ((d & 15) > NC + 1 || ((d >> 4) & 15) > NC + 1 || ((d >> 8) & 15) > NC + 1) bad = 1;
          default: bad = 1;
        endcase
        m_err = bad;
        if (!bad) begin
          case (int'(wr_addr))
            0: c_run[wr_idx] = d;
            1: c_ofs[wr_idx] = d;
            2: c_rep[wr_idx] = d;
            3: c_up[wr_idx] = d;
            4: c_dn[wr_idx] = d;
            default: begin
              c_sr[wr_idx] = d & 15;
              c_so[wr_idx] = (d >> 4) & 15;
              c_sc[wr_idx] = (d >> 8) & 15;
              c_pol[wr_idx] = d[12];
            end
          endcase
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      logic [NC-1:0] et, el;
      for (int i = 0; i < NC; i++) begin
        et[i] = m_tk[i];
        el[i] = m_lv[i];
      end
      checks++;
      if (tick_o !== et) begin
        fails++;
        $display("FAIL R2 R3 R4 R5 R6 tick_o actual %b expected %b at %0t", tick_o, et, $time);
      end
      checks++;
      if (lvl_o !== el) begin
        fails++;
        $display("FAIL R7 lvl_o actual %b expected %b at %0t", lvl_o, el, $time);
      end
      checks++;
      if (wr_err !== m_err) begin
        fails++;
        $display("FAIL R8 wr_err actual %b expected %b at %0t", wr_err, m_err, $time);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int addr, int data, output bit err);
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = 3'(idx);
    wr_addr = 3'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    err = wr_err;
    wr_en = 1'b0;
  endtask

  function automatic int selw(int r, int o, int c, int p);
    return r | (o << 4) | (c << 8) | (p << 12);
  endfunction

  task automatic prog(int idx, int run, int ofs, int rep, int up, int dn, int sel);
    bit e;
    int vals[6];
    vals = '{run, ofs, rep, up, dn, sel};
    for (int a = 0; a < 6; a++) begin
      wr(idx, a, vals[a], e);
      check("R1 good write flagged", int'(e), 0);
    end
  endtask

  task automatic count_ticks(int idx, int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt += int'(tick_o[idx]);
    end
  endtask

  task automatic finish_test();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired");
    finish_test();
  end

  initial begin
    bit e;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 tick after reset", int'(tick_o), 0);
    check("R10 lvl after reset", int'(lvl_o), 0);
    check("R10 err after reset", int'(wr_err), 0);

    // line strobe, delayed sync, frame, active row, active pixel, limited
    prog(0, 9, 0, 0, 0, 0, selw(1, 0, 0, 0));
    prog(1, 9, 3, 0, 0, 4, selw(1, 1, 0, 0));
    prog(2, 5, 0, 0, 0, 2, selw(2, 0, 0, 1));
    prog(3, 0, 1, 3, 0, 2, selw(3, 3, 4, 0));
    prog(4, 0, 2, 4, 0, 2, selw(1, 1, 5, 0));
    prog(5, 4, 0, 2, 2, 6, selw(1, 0, 0, 0));
    repeat (2) @(negedge clk);
    check("R9 stopped level equals polarity", int'(lvl_o), 'b000100);

    wr(0, 0, 'h1000, e); check("R8 run 0x1000 refused", int'(e), 1);
    wr(1, 3, 'h400, e);  check("R8 edge 0x400 refused", int'(e), 1);
    wr(1, 2, 'hFFF, e);  check("R8 repeat 0xFFF accepted", int'(e), 0);
    wr(1, 2, 0, e);      check("R8 repeat restore accepted", int'(e), 0);
    wr(6, 0, 1, e);      check("R8 index out of bank refused", int'(e), 1);
    wr(2, 5, selw(8, 0, 0, 1), e); check("R8 selector too large refused", int'(e), 1);
    wr(2, 6, 0, e);      check("R8 unused field refused", int'(e), 1);

    @(negedge clk);
    en = 1'b1;
    count_ticks(0, 100, n);
    check("R2 period-10 wraps in 100 cycles", n, 9);
    repeat (50) @(negedge clk);
    check("R5 limited counter stays quiet", int'(tick_o[5]), 0);
    repeat (600) @(negedge clk);

    en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no tick while stopped", int'(tick_o), 0);
    check("R9 stopped level equals polarity", int'(lvl_o), 'b000100);
    en = 1'b1;
    count_ticks(5, 100, n);
    check("R5 repeat-2 counter wraps twice", n, 2);

    // R6: restart the finished counter from the line strobe
    wr(5, 5, selw(1, 0, 2, 0), e);
    check("R6 clear-source write accepted", int'(e), 0);
    count_ticks(5, 100, n);
    check("R6 cleared counter wraps again", int'(n >= 9), 1);
    repeat (400) @(negedge clk);
    finish_test();
  end
endmodule